// File: doc/BRIEF.md
# Readback Check Comparator

This block runs the verify pass of a configuration download. While a download is in progress and the check mode is active, every word of the incoming stream is compared with the word already held at the same position of the configuration store, instead of being written there. The store is read through a simple address/data port. The address starts at zero when the download begins and advances by one with each accepted word.

Any difference pulls the shared init/status line low. The block only drives an open-drain enable (`init_pull_low`) and never drives the line high. The low level is sticky until reset or the start of the next download. The first failing address is also captured.

The check mode depends on an internal control bit, which is on after reset, and on the check request pin. The pin is looked at only while a download is in progress. Words arrive over a valid/ready stream. A word transfers on a cycle where both `s_valid` and `s_ready` are high. `s_ready` is high only while `dl_active` is high and fewer than DEPTH words have been accepted in the current download. This back-pressure holds the source once the store's address range is used up, and it also holds whenever no download is running. The sender may raise or drop `s_valid` at any time. A word that is not accepted is neither compared nor counted.

Top module: `cfg_verify_cmp`

## Requirements
- R1: After reset `init_pull_low` is 0, `bad_addr_vld` is 0, and the check control bit is 1 (enabled), so no control write is needed before a verify pass.
- R2: `mem_addr` is 0 on the first beat of a download and increases by one for each accepted word. The word compared on a beat is the one at `mem_addr` during that beat.
- R3: When an accepted word differs from `mem_rdata` while the check mode is active, `init_pull_low` is 1 from the next cycle on.
- R4: Once set, `init_pull_low` stays 1 across the end of the download and while idle. It is cleared only by reset or by the rising edge of `dl_active`. A mismatch on the first beat of the new download still sets it.
- R5: `bad_addr` holds the address of the first mismatch since the flag was last cleared, with `bad_addr_vld` = 1. Later mismatches leave it unchanged.
- R6: With the control bit written to 0 (`ctl_we` = 1, `ctl_chk_en` = 0), `chk_pin` has no effect, and mismatching words never set `init_pull_low`. Writing 1 restores the check.
- R7: While `dl_active` is 0, `s_ready` is 0, and `chk_pin` and `s_valid` have no effect on `init_pull_low`.
- R8: After DEPTH words have been accepted in one download, `s_ready` stays 0 until `dl_active` falls and rises again.
- R9: During a download with `chk_pin` = 0, words are accepted and counted, but no mismatch is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control bit write strobe |
| ctl_chk_en | input | 1 | Value written to the check enable control bit |
| dl_active | input | 1 | High while a configuration download is in progress |
| chk_pin | input | 1 | Check request pin, sampled only during a download |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Stream word accepted when high together with s_valid |
| s_data | input | DATA_W | Stream word |
| mem_addr | output | $clog2(DEPTH) | Read address into the configuration store |
| mem_rdata | input | DATA_W | Stored word at mem_addr (combinational read) |
| init_pull_low | output | 1 | Open-drain pull-low enable for the init/status line |
| bad_addr_vld | output | 1 | bad_addr holds a captured address |
| bad_addr | output | $clog2(DEPTH) | Address of the first mismatch |

## Verification
The bench builds the block with DATA_W = 16 and DEPTH = 8. A shallow store lets a single download run into the end-of-range back-pressure and the zero restart, which are the boundary cases of R2 and R8. It also lets the bench plant mismatches at chosen positions, including address 0 on the first beat, where the flag clear and the flag set fall on the same edge. The 16-bit words keep the stored pattern and the corrupted copies easy to tell apart in failure messages.

// File: rtl/cfgv_pkg.sv
package cfgv_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_PASS   = 2'd1,
    MODE_VERIFY = 2'd2
  } cfgv_mode_e;
endpackage

// File: rtl/cfgv_addr_seq.sv
module cfgv_addr_seq #(
  parameter int DEPTH = 1024,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             step,
  output logic [CNT_W-1:0] cnt,
  output logic             at_end
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (step)   cnt <= cnt + 1'b1;
  end

  assign at_end = (cnt == LAST);

  p_step_by_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step) |=> (cnt == $past(cnt) + 1'b1));
  p_idle_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
  p_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/cfgv_word_cmp.sv
module cfgv_word_cmp #(
  parameter int DATA_W = 32
) (
  input  logic              en,
  input  logic [DATA_W-1:0] seen,
  input  logic [DATA_W-1:0] held,
  output logic              miss
);
  logic [DATA_W-1:0] diff;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign diff[b] = seen[b] ^ held[b];
  end

  assign miss = en && (|diff);
endmodule

// File: rtl/cfgv_err_latch.sv
module cfgv_err_latch #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              set,
  input  logic [ADDR_W-1:0] set_addr,
  output logic              flag,
  output logic [ADDR_W-1:0] first_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag       <= 1'b0;
      first_addr <= '0;
    end else if (set && (clr || !flag)) begin
      flag       <= 1'b1;
      first_addr <= set_addr;
    end else if (clr) begin
      flag       <= 1'b0;
    end
  end

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  p_first_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> $stable(first_addr));
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);
endmodule

// File: rtl/cfg_verify_cmp.sv
module cfg_verify_cmp #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic              ctl_chk_en,
  input  logic              dl_active,
  input  logic              chk_pin,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              init_pull_low,
  output logic              bad_addr_vld,
  output logic [ADDR_W-1:0] bad_addr
);
  import cfgv_pkg::*;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             chk_en_q;
  logic             dl_q;
  logic             dl_start;
  logic             beat;
  logic             miss;
  logic             at_end;
  logic [CNT_W-1:0] cnt;
  cfgv_mode_e       mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      chk_en_q <= 1'b1;
    else if (ctl_we) chk_en_q <= ctl_chk_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dl_q <= 1'b0;
    else        dl_q <= dl_active;
  end

  assign dl_start = dl_active && !dl_q;

  always_comb begin
    if (!dl_active)                mode = MODE_IDLE;
    else if (chk_en_q && chk_pin)  mode = MODE_VERIFY;
    else                           mode = MODE_PASS;
  end

  assign s_ready = dl_active && !at_end;
  assign beat    = s_valid && s_ready;

  cfgv_addr_seq #(.DEPTH(DEPTH)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (dl_active),
    .step   (beat),
    .cnt    (cnt),
    .at_end (at_end)
  );

  assign mem_addr = cnt[ADDR_W-1:0];

  cfgv_word_cmp #(.DATA_W(DATA_W)) u_cmp (
    .en   (beat && (mode == MODE_VERIFY)),
    .seen (s_data),
    .held (mem_rdata),
    .miss (miss)
  );

  cfgv_err_latch #(.ADDR_W(ADDR_W)) u_err (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (dl_start),
    .set        (miss),
    .set_addr   (mem_addr),
    .flag       (init_pull_low),
    .first_addr (bad_addr)
  );

  assign bad_addr_vld = init_pull_low;

  p_flag_after_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && (mode == MODE_VERIFY) && (s_data != mem_rdata)) |=> init_pull_low);
  p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk_en_q && !init_pull_low) |=> !init_pull_low);
  p_idle_no_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dl_active |-> !s_ready);
  p_pin_low_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk_pin && !init_pull_low) |=> !init_pull_low);
  p_start_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dl_start |-> (mem_addr == '0));
endmodule

// File: tb/cfg_verify_cmp_tb.sv
module cfg_verify_cmp_tb;
  localparam int DW = 16;
  localparam int DP = 8;
  localparam int AW = $clog2(DP);

  typedef struct {
    logic          flag;
    logic [AW-1:0] addr;
    string         req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctl_we = 1'b0, ctl_chk_en = 1'b0;
  logic          dl_active = 1'b0, chk_pin = 1'b0, s_valid = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic          s_ready, init_pull_low, bad_addr_vld;
  logic [AW-1:0] mem_addr, bad_addr;
  logic [DW-1:0] mem_rdata;
  logic [DW-1:0] store [DP];

  int   checks = 0, errors = 0;
  exp_t q[$];
  logic m_flag;
  logic [AW-1:0] m_addr;

  always #10 clk = ~clk;

  assign mem_rdata = store[mem_addr];

  cfg_verify_cmp #(.DATA_W(DW), .DEPTH(DP)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_chk_en(ctl_chk_en),
    .dl_active(dl_active), .chk_pin(chk_pin), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .init_pull_low(init_pull_low), .bad_addr_vld(bad_addr_vld), .bad_addr(bad_addr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: compares result of each beat at the following falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(init_pull_low == e.flag, e.req, "init_pull_low", init_pull_low, e.flag);
        chk(bad_addr_vld == e.flag, e.req, "bad_addr_vld", bad_addr_vld, e.flag);
        if (e.flag) chk(bad_addr == e.addr, e.req, "bad_addr", bad_addr, e.addr);
      end
    end
  end

  // driver: a full download; entered and left at posedge+2
  task automatic download(input int n, input logic [DP-1:0] bad, input logic pin,
                          input logic active_chk, input string req);
    dl_active = 1'b1;
    chk_pin   = pin;
    m_flag    = 1'b0;
    for (int i = 0; i < n; i++) begin
      s_valid = 1'b1;
      s_data  = bad[i] ? (store[i] ^ 16'h0100) : store[i];
      @(negedge clk);
      chk(mem_addr == AW'(i), "R2", "mem_addr", mem_addr, i);
      chk(s_ready == 1'b1, "R8", "s_ready in range", s_ready, 1);
      @(posedge clk);
      if (bad[i] && active_chk && !m_flag) begin
        m_flag = 1'b1;
        m_addr = AW'(i);
      end
      q.push_back('{flag: m_flag, addr: m_addr, req: req});
      #2;
    end
    s_valid = 1'b0;
  endtask

  task automatic end_download;
    dl_active = 1'b0;
    chk_pin   = 1'b0;
    @(posedge clk); #2;
  endtask

  initial begin
    for (int i = 0; i < DP; i++) store[i] = 16'hA500 + DW'(i * 7);
    #35 rst_n = 1'b1;
    @(negedge clk);
    chk(init_pull_low == 0, "R1", "flag after reset", init_pull_low, 0);
    chk(bad_addr_vld == 0, "R1", "vld after reset", bad_addr_vld, 0);
    chk(s_ready == 0, "R7", "ready idle", s_ready, 0);
    @(posedge clk); #2;

    // R1/R2/R8: clean full pass, control never written
    download(DP, 8'h00, 1'b1, 1'b1, "R2");
    @(negedge clk);
    chk(s_ready == 0, "R8", "ready at end of range", s_ready, 0);
    s_valid = 1'b1; s_data = 16'hFFFF;
    @(posedge clk); #2;
    @(negedge clk);
    chk(s_ready == 0, "R8", "ready still low", s_ready, 0);
    chk(init_pull_low == 0, "R8", "extra word ignored", init_pull_low, 0);
    s_valid = 1'b0;
    end_download();

    // R3/R5/R1: mismatches at 3 and 5, default enable
    download(DP, 8'b0010_1000, 1'b1, 1'b1, "R3");
    end_download();
    @(negedge clk);
    chk(init_pull_low == 1, "R4", "flag held idle", init_pull_low, 1);
    chk(bad_addr == 3, "R5", "first address", bad_addr, 3);
    @(posedge clk); #2;

    // R4: new download start clears; R9: pin low, mismatches unreported
    download(4, 8'b0000_0110, 1'b0, 1'b0, "R9");
    end_download();

    // R6: control bit off
    ctl_we = 1'b1; ctl_chk_en = 1'b0;
    @(posedge clk); #2;
    ctl_we = 1'b0;
    download(DP, 8'hFF, 1'b1, 1'b0, "R6");
    end_download();

    // R7: idle with pin and valid high
    chk_pin = 1'b1; s_valid = 1'b1; s_data = 16'h1234;
    ctl_we = 1'b1; ctl_chk_en = 1'b1;
    @(posedge clk); #2;
    ctl_we = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    @(negedge clk);
    chk(init_pull_low == 0, "R7", "idle stimulus ignored", init_pull_low, 0);
    chk(s_ready == 0, "R7", "ready idle", s_ready, 0);
    s_valid = 1'b0; chk_pin = 1'b0;
    @(posedge clk); #2;

    // R6 re-enabled, R4: mismatch at address 0 on first beat, then restart
    download(2, 8'b0000_0011, 1'b1, 1'b1, "R6");
    end_download();
    download(1, 8'b0000_0001, 1'b1, 1'b1, "R4");
    end_download();
    @(negedge clk);
    chk(bad_addr == 0, "R5", "first address zero", bad_addr, 0);
    // R4: reset clears
    rst_n = 1'b0;
    #5;
    chk(init_pull_low == 0, "R4", "flag cleared by reset", init_pull_low, 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    @(posedge clk); #2;

    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule